// File: doc/BRIEF.md
# SMBus Indexed Block-Access Configuration Target

This block is a serial-bus target that lets a host read and write a bank of eight byte-wide configuration registers over a two-wire open-drain clock/data pair. SCL and SDA are brought into the system clock domain and oversampled, so the system clock must run at least sixteen times faster than SCL. This supports bus rates up to 400 kHz. The block drives SDA only by pulling it low.

Every transfer is indexed and carries a byte count. In a write, the host sends a starting index and a count, then the data bytes. In a read, the host sets the index with a short write, issues a repeated START and the read address, and the target answers with a count byte followed by register contents. The read count comes from a programmable register.

The 7-bit address has one strap-selected bit. The strap is captured once, on the first rising edge of the power-good input. The control bytes are exposed on ports for use elsewhere in the chip. The identification bytes are read-only.

Top module: `smb_cfg_target`

## Requirements
- R1: The address is 1101000 when the strap reads 0, and 1101010 when it reads 1. The strap is captured on the first rising edge of pwr_good. Later strap or pwr_good changes do not alter the address. Before that first edge, no address is acknowledged.
- R2: An address byte that does not match is not ACKed. The target then drives nothing until the next START.
- R3: A write consists of address with bit 0 = 0, index N, count X, then X data bytes. It stores the data at N, N+1, … and ACKs every byte.
- R4: Data bytes beyond the count X are NACKed and not stored.
- R5: A read consists of address with bit 0 = 1 after the index has been set. It returns first a count byte equal to {3'b000, reg7[4:0]}, then the data of indices N, N+1, … .
- R6: The index advances from 7 to 0. Indices 8 and above read as 0x00, and writes to them are ACKed but discarded.
- R7: After the host NACKs a byte it received, the target releases SDA and sends nothing further until the next START.
- R8: After reset, the registers read as follows: reg0 = 0xFF, reg1 = 0x00, reg2 = 0xFF, reg3 = 0x5F, reg7 = 0x08.
- R9: Some bits are read-only or reserved, and writes to them are ACKed but ignored: reg3[3:0] reads 1111, reg4 reads 0x00, reg5 reads {REV_ID, 4'b0001}, reg6 reads 0x08, and reg7[7:5] reads 000. The ports oe_mask, ctrl1, slew_fast and ref_ctrl follow reg0, reg1, reg2 and reg3[7:4].
- R10: A STOP in the middle of a byte discards that byte, returns the target to idle and releases SDA.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good; its first rise captures the address strap |
| addr_strap | input | 1 | Selects address bit 1 |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| oe_mask | output | 8 | Register 0, per-output enables |
| ctrl1 | output | 8 | Register 1, general control byte |
| slew_fast | output | 8 | Register 2, per-output slew select (1 = fast) |
| ref_ctrl | output | 4 | Register 3 bits [7:4] |

## Verification
The bench probes the address before and after the first power-good edge, then pulses power-good again with the strap changed. A design that re-samples the strap would move its address and stop answering. Block writes that overrun their count, start at index 7, or target indices 8 and above show whether the target stores a surplus byte, fails to wrap, or aliases high indices onto real registers. A read that the host NACKs early, followed by extra clocking, and a STOP after four bits of a data byte catch a target that keeps driving SDA or commits a partial byte. A bus monitor flags any change of the drive while SCL is high.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int REG_W  = 8;
  localparam int NREG   = 8;
  localparam int IDX_W  = 8;
  localparam int CNT_W  = 5;
  localparam int BIT_W  = 4;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(REG_W);
  localparam logic [4:0] ADDR_HI = 5'b11010;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INDEX, PH_COUNT, PH_WDATA, PH_TX, PH_HOLD
  } phase_t;

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(NREG - 1)) ? '0 : i + 1'b1;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [CNT_W-1:0] rd_count,
  output logic [REG_W-1:0] oe_mask,
  output logic [REG_W-1:0] ctrl1,
  output logic [REG_W-1:0] slew_fast,
  output logic [3:0]       ref_ctrl
);
  localparam logic [REG_W-1:0] R0_RST = 8'hFF;
  localparam logic [REG_W-1:0] R1_RST = 8'h00;
  localparam logic [REG_W-1:0] R2_RST = 8'hFF;
  localparam logic [3:0]       R3_RST = 4'h5;
  localparam logic [3:0]       R3_FIX = 4'hF;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(8);
  localparam logic [REG_W-1:0] ID_BYTE = 8'h08;
  localparam logic [3:0]       VEND    = 4'b0001;

  logic [REG_W-1:0] r0_q, r0_n, r1_q, r1_n, r2_q, r2_n;
  logic [3:0]       r3_q, r3_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic en0, en1, en2, en3, en7;

  always_comb begin
    en0 = wr_en && (idx == IDX_W'(0));
    en1 = wr_en && (idx == IDX_W'(1));
    en2 = wr_en && (idx == IDX_W'(2));
    en3 = wr_en && (idx == IDX_W'(3));
    en7 = wr_en && (idx == IDX_W'(7));
    r0_n  = en0 ? wr_data : r0_q;
    r1_n  = en1 ? wr_data : r1_q;
    r2_n  = en2 ? wr_data : r2_q;
    r3_n  = en3 ? wr_data[7:4] : r3_q;
    cnt_n = en7 ? wr_data[CNT_W-1:0] : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q  <= R0_RST;
      r1_q  <= R1_RST;
      r2_q  <= R2_RST;
      r3_q  <= R3_RST;
      cnt_q <= CNT_RST;
    end else begin
      r0_q  <= r0_n;
      r1_q  <= r1_n;
      r2_q  <= r2_n;
      r3_q  <= r3_n;
      cnt_q <= cnt_n;
    end
  end

  always_comb begin
    case (idx)
      IDX_W'(0): rd_data = r0_q;
      IDX_W'(1): rd_data = r1_q;
      IDX_W'(2): rd_data = r2_q;
      IDX_W'(3): rd_data = {r3_q, R3_FIX};
      IDX_W'(5): rd_data = {REV_ID, VEND};
      IDX_W'(6): rd_data = ID_BYTE;
      IDX_W'(7): rd_data = {{(REG_W-CNT_W){1'b0}}, cnt_q};
      default:   rd_data = '0;
    endcase
  end

  assign rd_count  = cnt_q;
  assign oe_mask   = r0_q;
  assign ctrl1     = r1_q;
  assign slew_fast = r2_q;
  assign ref_ctrl  = r3_q;

  // R3
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(0)) |=> (oe_mask == $past(wr_data)));
  // R9
  count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(7)) |=> (rd_count == $past(wr_data[CNT_W-1:0])));
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             enable,
  input  logic [6:0]       my_addr,
  input  logic [REG_W-1:0] rd_data,
  input  logic [CNT_W-1:0] rd_count,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] cur_idx,
  output logic [REG_W-1:0] cur_byte
);
  phase_t            phase_q, phase_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic              ack_q, ack_n, acked_q, acked_n, rw_q, rw_n;
  logic              oe_q, oe_n, hnack_q, hnack_n;
  logic [REG_W-1:0]  sh_q, sh_n, rem_q, rem_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              scl_d, sda_d;
  logic              scl_rise, scl_fall, start_ev, stop_ev;

  always_comb begin
    scl_rise = scl_s & ~scl_d;
    scl_fall = ~scl_s & scl_d;
    start_ev = scl_s & scl_d & sda_d & ~sda_s;
    stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  end

  always_comb begin
    phase_n = phase_q; bit_n = bit_q; ack_n = ack_q; acked_n = acked_q;
    rw_n = rw_q; sh_n = sh_q; oe_n = oe_q; idx_n = idx_q; rem_n = rem_q;
    hnack_n = hnack_q; wr_en = 1'b0;
    if (start_ev && enable) begin
      phase_n = PH_ADDR; bit_n = '0; ack_n = 1'b0; oe_n = 1'b0; hnack_n = 1'b0;
    end else if (stop_ev) begin
      phase_n = PH_IDLE; bit_n = '0; ack_n = 1'b0; oe_n = 1'b0;
    end else if (phase_q != PH_IDLE && phase_q != PH_HOLD) begin
      if (scl_rise) begin
        if (ack_q) begin
          if (phase_q == PH_TX) hnack_n = sda_s;
        end else if (bit_q != BIT_LAST) begin
          bit_n = bit_q + 1'b1;
          if (phase_q != PH_TX) sh_n = {sh_q[REG_W-2:0], sda_s};
        end
      end else if (scl_fall) begin
        if (!ack_q && bit_q == BIT_LAST) begin
          ack_n = 1'b1;
          acked_n = 1'b1;
          case (phase_q)
            PH_ADDR: begin
              acked_n = (sh_q[7:1] == my_addr);
              rw_n    = sh_q[0];
            end
            PH_INDEX: idx_n = sh_q;
            PH_COUNT: rem_n = sh_q;
            PH_WDATA: begin
              if (rem_q != '0) begin
                wr_en = 1'b1;
                rem_n = rem_q - 1'b1;
                idx_n = idx_step(idx_q);
              end else begin
                acked_n = 1'b0;
              end
            end
            PH_TX: acked_n = 1'b0;
            default: acked_n = 1'b0;
          endcase
          oe_n = acked_n;
        end else if (ack_q) begin
          ack_n = 1'b0; bit_n = '0; oe_n = 1'b0;
          case (phase_q)
            PH_ADDR: begin
              if (!acked_q) phase_n = PH_HOLD;
              else if (rw_q) begin
                sh_n = {{(REG_W-CNT_W){1'b0}}, rd_count};
                oe_n = ~sh_n[REG_W-1];
                hnack_n = 1'b0;
                phase_n = PH_TX;
              end else phase_n = PH_INDEX;
            end
            PH_INDEX: phase_n = PH_COUNT;
            PH_COUNT: phase_n = PH_WDATA;
            PH_TX: begin
              if (hnack_q) phase_n = PH_HOLD;
              else begin
                sh_n  = rd_data;
                oe_n  = ~rd_data[REG_W-1];
                idx_n = idx_step(idx_q);
              end
            end
            default: phase_n = phase_q;
          endcase
        end else if (phase_q == PH_TX && bit_q != '0) begin
          sh_n = {sh_q[REG_W-2:0], 1'b0};
          oe_n = ~sh_q[REG_W-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; bit_q <= '0; ack_q <= 1'b0; acked_q <= 1'b0;
      rw_q <= 1'b0; sh_q <= '0; oe_q <= 1'b0; idx_q <= '0; rem_q <= '0;
      hnack_q <= 1'b0; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      phase_q <= phase_n; bit_q <= bit_n; ack_q <= ack_n; acked_q <= acked_n;
      rw_q <= rw_n; sh_q <= sh_n; oe_q <= oe_n; idx_q <= idx_n; rem_q <= rem_n;
      hnack_q <= hnack_n; scl_d <= scl_s; sda_d <= sda_s;
    end
  end

  assign sda_oe   = oe_q;
  assign cur_idx  = idx_q;
  assign cur_byte = sh_q;

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (phase_q == PH_IDLE && !oe_q));
  // R11
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s);
  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && ack_q && phase_q == PH_TX && hnack_q && !start_ev && !stop_ev)
      |=> (!oe_q && phase_q == PH_HOLD));
  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE || phase_q == PH_HOLD) |-> !oe_q);
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       addr_strap,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  output logic [7:0] oe_mask,
  output logic [7:0] ctrl1,
  output logic [7:0] slew_fast,
  output logic [3:0] ref_ctrl
);
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  logic [2:0] raw_v, sync_v;
  logic scl_s, sda_s, pg_s;
  assign raw_v = {pwr_good, sda_in, scl_in};

  smb_line_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_i), .d(raw_v), .q(sync_v)
  );
  assign scl_s = sync_v[0];
  assign sda_s = sync_v[1];
  assign pg_s  = sync_v[2];

  logic pg_d, strap_q, strap_n, done_q, done_n, cap;
  always_comb begin
    cap     = pg_s & ~pg_d & ~done_q;
    strap_n = cap ? addr_strap : strap_q;
    done_n  = done_q | cap;
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pg_d <= 1'b0; strap_q <= 1'b0; done_q <= 1'b0;
    end else begin
      pg_d <= pg_s; strap_q <= strap_n; done_q <= done_n;
    end
  end

  logic [6:0]       my_addr;
  logic             wr_en;
  logic [IDX_W-1:0] cur_idx;
  logic [REG_W-1:0] cur_byte, rd_data;
  logic [CNT_W-1:0] rd_count;
  assign my_addr = {ADDR_HI, strap_q, 1'b0};

  smb_proto_fsm u_fsm (
    .clk(clk), .rst_n(rst_i), .scl_s(scl_s), .sda_s(sda_s), .enable(done_q),
    .my_addr(my_addr), .rd_data(rd_data), .rd_count(rd_count),
    .sda_oe(sda_drive_low), .wr_en(wr_en), .cur_idx(cur_idx), .cur_byte(cur_byte)
  );

  smb_cfg_regs #(.REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .idx(cur_idx), .wr_data(cur_byte),
    .rd_data(rd_data), .rd_count(rd_count), .oe_mask(oe_mask), .ctrl1(ctrl1),
    .slew_fast(slew_fast), .ref_ctrl(ref_ctrl)
  );

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (done_q && $past(done_q)) |-> $stable(strap_q));
endmodule

// File: tb/sim_smb_cfg_target.sv
module sim_smb_cfg_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic addr_strap = 1'b1;
  logic scl_h = 1'b1;
  logic sda_host = 1'b1;
  logic sda_drive_low;
  logic [7:0] oe_mask, ctrl1, slew_fast;
  logic [3:0] ref_ctrl;
  wire  sda_line = sda_host & ~sda_drive_low;

  int total = 0;
  int bad = 0;
  int r11_viol = 0;
  localparam int H = 20;

  always #2.5 clk = ~clk;

  smb_cfg_target u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .addr_strap(addr_strap),
    .scl_in(scl_h), .sda_in(sda_line), .sda_drive_low(sda_drive_low),
    .oe_mask(oe_mask), .ctrl1(ctrl1), .slew_fast(slew_fast), .ref_ctrl(ref_ctrl)
  );

  // R11 monitor: drive changes seen while SCL is high
  always @(sda_drive_low) if (rst_n && scl_h) r11_viol++;

  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];
  logic [7:0] rcnt;
  int wacks;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart();
    sda_host = 1'b1; wt(H/2); scl_h = 1'b1; wt(H); sda_host = 1'b0; wt(H); scl_h = 1'b0;
  endtask

  task automatic bstop();
    wt(H/2); sda_host = 1'b0; wt(H/2); scl_h = 1'b1; wt(H); sda_host = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    wt(H/2); sda_host = b; wt(H/2); scl_h = 1'b1; wt(H); scl_h = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ak);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wt(H/2); sda_host = 1'b1; wt(H/2); scl_h = 1'b1; wt(H/2);
    ak = ~sda_line; wt(H/2); scl_h = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      wt(H/2); sda_host = 1'b1; wt(H/2); scl_h = 1'b1; wt(H/2);
      b[i] = sda_line; wt(H/2); scl_h = 1'b0;
    end
    wt(H/2); sda_host = ~ack; wt(H/2); scl_h = 1'b1; wt(H); scl_h = 1'b0;
    wt(H/2); sda_host = 1'b1; wt(1);
  endtask

  task automatic probe_addr(input logic [7:0] ab, output logic ak);
    bstart(); send_byte(ab, ak); bstop();
  endtask

  task automatic write_block(input logic [7:0] idx, input logic [7:0] cnt, input int nd);
    logic ak;
    wacks = 0;
    bstart();
    send_byte(8'hD4, ak); wacks += ak;
    send_byte(idx, ak);   wacks += ak;
    send_byte(cnt, ak);   wacks += ak;
    for (int i = 0; i < nd; i++) begin send_byte(wbuf[i], ak); wacks += ak; end
    bstop();
  endtask

  task automatic read_block(input logic [7:0] idx, input int nd);
    logic ak;
    bstart();
    send_byte(8'hD4, ak); send_byte(idx, ak);
    bstart();
    send_byte(8'hD5, ak);
    recv_byte(rcnt, 1'b1);
    for (int i = 0; i < nd; i++) recv_byte(rbuf[i], i != nd - 1);
    bstop();
  endtask

  task automatic t_strap();
    logic ak;
    probe_addr(8'hD4, ak); check("R1 no ack before power-good", ak, 0);
    pwr_good = 1'b1; wt(10); addr_strap = 1'b0; wt(10);
    probe_addr(8'hD0, ak); check("R2 other address not acked", ak, 0);
    probe_addr(8'hD4, ak); check("R1 strap-high address acked", ak, 1);
    pwr_good = 1'b0; wt(10); pwr_good = 1'b1; wt(10);
    probe_addr(8'hD4, ak); check("R1 address kept after re-pulse", ak, 1);
    probe_addr(8'hD0, ak); check("R1 strap change ignored", ak, 0);
    bstart(); send_byte(8'hD0, ak); send_byte(8'h00, ak);
    check("R2 target off bus after mismatch", ak, 0); bstop();
  endtask

  task automatic t_reset();
    logic [7:0] ex [0:7];
    ex = '{8'hFF, 8'h00, 8'hFF, 8'h5F, 8'h00, 8'h11, 8'h08, 8'h08};
    read_block(8'h00, 8);
    check("R5 count byte after reset", rcnt, 8'h08);
    for (int i = 0; i < 8; i++) check($sformatf("R8 reset reg%0d", i), rbuf[i], ex[i]);
  endtask

  task automatic t_write();
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hC3;
    write_block(8'h01, 8'h03, 3);
    check("R3 all bytes acked", wacks, 6);
    read_block(8'h01, 3);
    check("R3 reg1", rbuf[0], 8'hA5);
    check("R3 reg2", rbuf[1], 8'h3C);
    check("R9 reg3 reserved low bits", rbuf[2], 8'hCF);
    check("R9 ctrl1 port", ctrl1, 8'hA5);
    check("R9 slew port", slew_fast, 8'h3C);
    check("R9 ref_ctrl port", ref_ctrl, 4'hC);
  endtask

  task automatic t_overflow();
    wbuf[0] = 8'h0F; wbuf[1] = 8'h11;
    write_block(8'h00, 8'h01, 2);
    check("R4 surplus byte NACKed", wacks, 4);
    read_block(8'h00, 2);
    check("R4 reg0 written", rbuf[0], 8'h0F);
    check("R4 reg1 untouched", rbuf[1], 8'hA5);
    check("R9 oe_mask port", oe_mask, 8'h0F);
  endtask

  task automatic t_readonly();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_block(8'h04, 8'h03, 3);
    check("R9 read-only writes acked", wacks, 6);
    read_block(8'h04, 3);
    check("R9 reg4 reserved", rbuf[0], 8'h00);
    check("R9 reg5 id", rbuf[1], 8'h11);
    check("R9 reg6 id", rbuf[2], 8'h08);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hE3; wbuf[1] = 8'h5A;
    write_block(8'h07, 8'h02, 2);
    check("R6 wrap write acked", wacks, 5);
    check("R6 wrapped write to reg0", oe_mask, 8'h5A);
    read_block(8'h06, 3);
    check("R5 programmed count", rcnt, 8'h03);
    check("R6 reg6 before wrap", rbuf[0], 8'h08);
    check("R9 reg7 upper bits zero", rbuf[1], 8'h03);
    check("R6 wrap to reg0", rbuf[2], 8'h5A);
  endtask

  task automatic t_high_idx();
    wbuf[0] = 8'h77;
    write_block(8'h09, 8'h01, 1);
    check("R6 high index write acked", wacks, 4);
    read_block(8'h09, 3);
    check("R6 idx9 reads zero", rbuf[0], 8'h00);
    check("R6 idx10 reads zero", rbuf[1], 8'h00);
    check("R6 idx11 reads zero", rbuf[2], 8'h00);
    check("R6 real registers untouched", oe_mask, 8'h5A);
  endtask

  task automatic t_nack();
    logic ak;
    logic [7:0] b;
    bstart(); send_byte(8'hD4, ak); send_byte(8'h00, ak);
    bstart(); send_byte(8'hD5, ak);
    recv_byte(b, 1'b1);
    recv_byte(b, 1'b0);
    check("R7 data before NACK", b, 8'h5A);
    recv_byte(b, 1'b0);
    check("R7 target silent after NACK", b, 8'hFF);
    check("R7 SDA released", sda_drive_low, 1'b0);
    bstop();
  endtask

  task automatic t_abort();
    logic ak;
    bstart(); send_byte(8'hD4, ak); send_byte(8'h00, ak); send_byte(8'h01, ak);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bstop();
    check("R10 partial byte discarded", oe_mask, 8'h5A);
    check("R10 SDA released after STOP", sda_drive_low, 1'b0);
    read_block(8'h00, 1);
    check("R10 normal access after abort", rbuf[0], 8'h5A);
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(10);
    check("R9 reset oe_mask", oe_mask, 8'hFF);
    check("R8 reset ref_ctrl", ref_ctrl, 4'h5);
    check("R8 no drive after reset", sda_drive_low, 1'b0);
    t_strap();
    t_reset();
    t_write();
    t_overflow();
    t_readonly();
    t_wrap();
    t_high_idx();
    t_nack();
    t_abort();
    check("R11 drive changes with SCL high", r11_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule